// File: doc/BRIEF.md
# Two-Channel Time-of-Day Alarm with Interrupt Routing

This unit watches the running calendar time and raises an interrupt when it reaches either of two programmed alarm settings. Each setting holds four byte fields: second, minute, hour and weekday. The fields use the same encoding as the time inputs. Any field can be made a wildcard by setting its top bit. Such a field matches every time value, which lets an alarm fire every second, every minute, every hour or every day.

The time inputs are compared once per second, in the cycle that carries the one-second strobe. A full match latches a pending flag for that channel, whether or not its interrupt is enabled. A register bus reads and writes the alarm fields, a control byte and a status byte. Reading any field of a channel acknowledges that channel. Writing zeros into the status byte also clears flags.

Channel 0 always signals on the active-low interrupt pin. A routing bit sends channel 1 either to the same pin or to a separate active-high pin. Interrupt pins, pending flags and read data are all registered.

Top module: `alarm_irq_unit`

## Requirements
- R1: Alarm channel 0 fields sit at addresses 0x07 (second), 0x08 (minute), 0x09 (hour) and 0x0A (weekday). Channel 1 fields sit at 0x0B to 0x0E in the same field order. A written byte reads back on `bus_rdata` one cycle after the read strobe.
- R2: In a cycle with `tick` high, if all four fields of a channel equal the time inputs, that channel's pending flag is set after the clock edge. A single mismatching unmasked field prevents the set.
- R3: A field whose bit 7 is 1 matches any time value.
- R4: Without `tick`, no flag is set. With `tick`, a match sets the flag even when its enable is 0.
- R5: A read of any address in a channel's field range clears that channel's flag and leaves the other channel's flag unchanged.
- R6: The status byte is at 0x10 and holds the channel 0 flag in bit 0 and the channel 1 flag in bit 1. Its other bits read as 0. Writing it clears each flag whose data bit is 0; a data bit of 1 leaves the flag unchanged.
- R7: When a match and a clearing access to the same channel fall in the same cycle, the flag ends up set.
- R8: The control byte is at 0x10 minus one (0x0F). Bit 0 enables channel 0 and bit 1 enables channel 1. One cycle after channel 0's flag and enable are both 1, `int0_n` is driven low. It returns high one cycle after either of them drops.
- R9: Control bit 2 routes channel 1. When it is 0, channel 1 (flag and enable) drives `int0_n` low and `int1` stays 0. When it is 1, channel 1 drives `int1` high instead. Both pins follow with one cycle of delay.
- R10: After reset, all flags, the control byte and the alarm fields are 0, `int0_n` is 1 and `int1` is 0. The control byte reads back bits 2:0 with its upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second strobe, one cycle wide, asserted after the time has updated |
| now_sec | input | 8 | Current seconds field |
| now_min | input | 8 | Current minutes field |
| now_hour | input | 8 | Current hours field |
| now_wday | input | 8 | Current weekday field |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_re` |
| pend | output | 2 | Pending flags, bit k for channel k |
| int0_n | output | 1 | Active-low interrupt, channel 0 and optionally channel 1 |
| int1 | output | 1 | Active-high interrupt for channel 1 when routed |

## Verification
The bench builds the unit with its default parameters: an 8-bit address and the field block starting at 0x07. With these values the control and status bytes land at 0x0F and 0x10. Because the time inputs are driven directly, any match condition can be reached within a few cycles without counting real seconds. This makes it possible to set up the same-cycle collision of a match with an acknowledging read, and each routing setting of channel 1, on demand.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;
  localparam int DW     = 8;
  localparam int FIELDS = 4;
  localparam int IW     = $clog2(FIELDS);
  typedef logic [DW-1:0] byte_t;
  typedef logic [FIELDS-1:0][DW-1:0] tod_t;  // [0]=sec [1]=min [2]=hour [3]=wday
endpackage

// File: rtl/alarm_set.sv
`timescale 1ns/1ps
module alarm_set
  import alarm_irq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int BASE = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  input  tod_t          now,
  output logic          sel,
  output byte_t         rd_val,
  output logic          match
);
  localparam int LAST = BASE + FIELDS - 1;

  byte_t          fld [FIELDS];
  logic [IW-1:0]  idx;
  logic [FIELDS-1:0] fm;

  assign sel = (addr >= AW'(BASE)) && (addr <= AW'(LAST));
  assign idx = addr[IW-1:0] - IW'(BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FIELDS; i++) fld[i] <= '0;
    end else if (we && sel) begin
      fld[idx] <= wdata;
    end
  end

  generate
    for (genvar f = 0; f < FIELDS; f++) begin : g_cmp
      assign fm[f] = fld[f][DW-1] | (fld[f] == now[f]);
    end
  endgenerate

  assign match  = &fm;
  assign rd_val = fld[idx];
endmodule

// File: rtl/alarm_irq_pins.sv
`timescale 1ns/1ps
module alarm_irq_pins (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pend,
  input  logic [1:0] en,
  input  logic       route,
  output logic       int0_n,
  output logic       int1
);
  logic act0, act1;
  assign act0 = pend[0] & en[0];
  assign act1 = pend[1] & en[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      int0_n <= 1'b1;
      int1   <= 1'b0;
    end else begin
      int0_n <= ~(act0 | (act1 & ~route));
      int1   <= act1 & route;
    end
  end

  a_r8_int0_low: assert property (@(posedge clk) disable iff (rst)
    act0 |=> !int0_n);
  a_r9_int1_quiet: assert property (@(posedge clk) disable iff (rst)
    !route |=> !int1);
endmodule

// File: rtl/alarm_irq_unit.sv
`timescale 1ns/1ps
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int ALM_BASE = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [7:0]    now_sec,
  input  logic [7:0]    now_min,
  input  logic [7:0]    now_hour,
  input  logic [7:0]    now_wday,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [1:0]    pend,
  output logic          int0_n,
  output logic          int1
);
  localparam int NCH       = 2;
  localparam int CTRL_ADDR = ALM_BASE + NCH * FIELDS;
  localparam int STAT_ADDR = CTRL_ADDR + 1;

  tod_t           now;
  logic [NCH-1:0] sel, match, set_c, clr_c;
  byte_t          rdv [NCH];
  logic [2:0]     ctrl;
  logic           ctrl_hit, stat_hit;

  assign now = {now_wday, now_hour, now_min, now_sec};
  assign ctrl_hit = (bus_addr == AW'(CTRL_ADDR));
  assign stat_hit = (bus_addr == AW'(STAT_ADDR));

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      alarm_set #(.AW(AW), .BASE(ALM_BASE + k * FIELDS)) u_set (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .now(now), .sel(sel[k]), .rd_val(rdv[k]), .match(match[k])
      );
      assign set_c[k] = tick & match[k];
      assign clr_c[k] = (bus_re & sel[k]) | (bus_we & stat_hit & ~bus_wdata[k]);

      always_ff @(posedge clk) begin
        if (rst)           pend[k] <= 1'b0;
        else if (set_c[k]) pend[k] <= 1'b1;
        else if (clr_c[k]) pend[k] <= 1'b0;
      end

      a_r5_read_acks: assert property (@(posedge clk) disable iff (rst)
        (bus_re && sel[k] && !(tick && match[k])) |=> !pend[k]);
      a_r7_match_wins: assert property (@(posedge clk) disable iff (rst)
        (tick && match[k]) |=> pend[k]);
      a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!pend[k] && !tick) |=> !pend[k]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                   ctrl <= '0;
    else if (bus_we && ctrl_hit) ctrl <= bus_wdata[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (sel[0])        bus_rdata <= rdv[0];
      else if (sel[1])   bus_rdata <= rdv[1];
      else if (ctrl_hit) bus_rdata <= {5'b0, ctrl};
      else if (stat_hit) bus_rdata <= {6'b0, pend};
      else               bus_rdata <= '0;
    end
  end

  alarm_irq_pins u_pins (
    .clk(clk), .rst(rst), .pend(pend), .en(ctrl[1:0]), .route(ctrl[2]),
    .int0_n(int0_n), .int1(int1)
  );

  a_r10_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel, ctrl_hit, stat_hit}));
endmodule

// File: tb/alarm_irq_unit_bench.sv
`timescale 1ns/1ps
module alarm_irq_unit_bench;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [7:0] now_sec = 8'h30, now_min = 8'h15, now_hour = 8'h09, now_wday = 8'h03;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] pend;
  logic       int0_n, int1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_irq_unit u_alarm_irq_unit (
    .clk(clk), .rst(rst), .tick(tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_wday(now_wday), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend), .int0_n(int0_n), .int1(int1)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 pend", {6'b0, pend}, 8'h00);
    chk("R10 int0_n", {7'b0, int0_n}, 8'h01);
    chk("R10 int1", {7'b0, int1}, 8'h00);
    rd(8'h0F, d); chk("R10 ctrl", d, 8'h00);
    rd(8'h0B, d); chk("R10 field", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(8'h07, 8'h30); wr(8'h08, 8'h15); wr(8'h09, 8'h09); wr(8'h0A, 8'h03);
    wr(8'h0B, 8'h30); wr(8'h0C, 8'h80); wr(8'h0D, 8'h80); wr(8'h0E, 8'h80);
    rd(8'h09, d); chk("R1 a0 hour", d, 8'h09);
    rd(8'h0A, d); chk("R1 a0 wday", d, 8'h03);
    rd(8'h0D, d); chk("R1 a1 hour", d, 8'h80);
    rd(8'h0B, d); chk("R1 a1 sec", d, 8'h30);
  endtask

  task automatic t_match();
    now_hour = 8'h10;
    repeat (3) settle();
    chk("R4 no tick", {6'b0, pend}, 8'h00);
    pulse();
    chk("R2/R3 only masked ch1", {6'b0, pend}, 8'h02);
    wr(8'h10, 8'h00);
    chk("R6 clear all", {6'b0, pend}, 8'h00);
    now_hour = 8'h09;
    pulse();
    chk("R2/R4 both, enables off", {6'b0, pend}, 8'h03);
    settle();
    chk("R8 disabled stays high", {7'b0, int0_n}, 8'h01);
  endtask

  task automatic t_rdclr();
    logic [7:0] d;
    rd(8'h0D, d);
    chk("R5 ch1 acked", {6'b0, pend}, 8'h01);
    rd(8'h08, d);
    chk("R5 ch0 acked", {6'b0, pend}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    pulse();
    wr(8'h10, 8'h02);
    chk("R6 partial clear", {6'b0, pend}, 8'h02);
    rd(8'h10, d);
    chk("R6 status read", d, 8'h02);
    wr(8'h10, 8'h00);
    chk("R6 cleared", {6'b0, pend}, 8'h00);
  endtask

  task automatic t_race();
    @(negedge clk); tick = 1'b1; bus_re = 1'b1; bus_addr = 8'h07;
    @(negedge clk); tick = 1'b0; bus_re = 1'b0;
    chk("R7 match over read", {6'b0, pend}, 8'h03);
    wr(8'h10, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(8'h0F, 8'h01);
    pulse(); settle();
    chk("R8 int0 low", {7'b0, int0_n}, 8'h00);
    chk("R8 int1 low", {7'b0, int1}, 8'h00);
    rd(8'h07, d); settle();
    chk("R8 int0 released", {7'b0, int0_n}, 8'h01);
    wr(8'h0F, 8'h02); settle();
    chk("R9 shared pin", {7'b0, int0_n}, 8'h00);
    chk("R9 shared int1", {7'b0, int1}, 8'h00);
    wr(8'h0F, 8'h06); settle();
    chk("R9 routed int0", {7'b0, int0_n}, 8'h01);
    chk("R9 routed int1", {7'b0, int1}, 8'h01);
    rd(8'h0F, d);
    chk("R10 ctrl readback", d, 8'h06);
    wr(8'h10, 8'h00); settle();
    chk("R9 int1 released", {7'b0, int1}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_regs();
    t_match();
    t_rdclr();
    t_status();
    t_race();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule